// File: doc/BRIEF.md
# Power Management Control Register

This block is a 16-bit power management control register reached over a small I/O bus. Software can write or read it as a whole word, or one byte lane at a time. The register holds an interrupt-enable bit, a global-release bit and a three-bit sleep type field. It also decodes a sleep-enable strobe bit.

The sleep-enable bit is never stored. When a write sets that strobe and the written sleep type is the soft-off code 000, the block raises a shutdown request for exactly one clock. The request appears on the clock after the write is taken. The power sequencer downstream uses this request to remove power. Any other sleep type, including the reserved code 111, gives no request.

Reads are combinational. Two bits always read as zero: the global-release bit, which is stored but hidden, and the sleep-enable strobe.

Top module: `pmctl_reg`

## Requirements
- R1: After a synchronous active-high reset the register reads 0x0000 and `shutdown_req` is low.
- R2: A word write (`size_word`=1) stores all of `wdata` except bit 13. A word read then returns the stored value with bit 2 and bit 13 forced to 0.
- R3: A low-lane byte write (`size_word`=0, `addr_hi`=0) replaces bits 7:0 with `wdata[7:0]`. Bits 15:8 keep their value, and `wdata[15:8]` is ignored.
- R4: A high-lane byte write (`size_word`=0, `addr_hi`=1) replaces bits 15:8 with `wdata[7:0]`, clearing the lane's bit 5 (register bit 13). Bits 7:0 keep their value.
- R5: A byte read returns the selected lane in `rdata[7:0]`, with `rdata[15:8]` = 0. The same masking as R2 applies. When `rd_en` is low, `rdata` is 0.
- R6: A word write with `wdata[13]`=1 and `wdata[12:10]`=000 drives `shutdown_req` high for exactly the one cycle after the write edge.
- R7: A high-lane byte write with `wdata[5]`=1 and `wdata[4:2]`=000 drives `shutdown_req` high for the one cycle after the write edge.
- R8: A write that sets the sleep-enable bit with a nonzero sleep type (001 through 111) produces no shutdown request. So does a write with sleep-enable clear.
- R9: A low-lane byte write never produces a shutdown request, whatever its data.
- R10: A read in the same cycle as a write returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| rd_en | input | 1 | Read strobe, data returned in the same cycle |
| size_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr_hi | input | 1 | Byte lane select for byte access (1 = bits 15:8) |
| wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rdata | output | 16 | Read data, zero-extended for byte reads |
| shutdown_req | output | 1 | One-cycle soft-off request |

## Verification
The checker assumes every control input is at a defined level from the first clock edge. It also assumes a write is seen only on edges where `wr_en` is sampled high, and that `addr_hi` is don't-care on word accesses. The bench drives all inputs on the falling edge from time zero. It holds the strobes low outside the access it performs and returns to idle between vectors. As a result, each pulse can be traced to exactly one write, and each read samples a settled register.

// File: rtl/pmctl_pkg.sv
package pmctl_pkg;

    localparam int unsigned REG_W    = 16;
    localparam int unsigned LANE_W   = REG_W / 2;
    localparam int unsigned IRQ_BIT  = 0;
    localparam int unsigned GREL_BIT = 2;
    localparam int unsigned TYPE_LSB = 10;
    localparam int unsigned TYPE_W   = 3;
    localparam int unsigned SLP_BIT  = 13;
    localparam logic [TYPE_W-1:0] SOFT_OFF_CODE = '0;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    typedef struct packed {
        logic              load;
        logic [REG_W-1:0]  next_val;
        logic              fire;
    } upd_t;

    function automatic logic [REG_W-1:0] slp_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[SLP_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] hide_mask();
        logic [REG_W-1:0] m;
        m = slp_mask();
        m[GREL_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic is_soft_off(input logic [REG_W-1:0] v);
        return v[SLP_BIT] && (v[TYPE_LSB +: TYPE_W] == SOFT_OFF_CODE);
    endfunction

    function automatic acc_e classify(input logic wr, input logic word, input logic hi);
        if (!wr)  return ACC_NONE;
        if (word) return ACC_WORD;
        return hi ? ACC_HI : ACC_LO;
    endfunction

endpackage

// File: rtl/pmctl_decode.sv
module pmctl_decode
    import pmctl_pkg::*;
(
    input  logic             wr_en,
    input  logic             size_word,
    input  logic             addr_hi,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] cur,
    output upd_t             upd
);
    acc_e             kind;
    logic [REG_W-1:0] hi_view;

    assign kind    = classify(wr_en, size_word, addr_hi);
    assign hi_view = {wdata[LANE_W-1:0], {LANE_W{1'b0}}};

    always_comb begin
        upd = '{load: 1'b0, next_val: cur, fire: 1'b0};
        unique case (kind)
            ACC_WORD: begin
                upd.load     = 1'b1;
                upd.next_val = wdata & ~slp_mask();
                upd.fire     = is_soft_off(wdata);
            end
            ACC_HI: begin
                upd.load     = 1'b1;
                upd.next_val = {wdata[LANE_W-1:0], cur[LANE_W-1:0]} & ~slp_mask();
                upd.fire     = is_soft_off(hi_view);
            end
            ACC_LO: begin
                upd.load     = 1'b1;
                upd.next_val = {cur[REG_W-1:LANE_W], wdata[LANE_W-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pmctl_store.sv
module pmctl_store
    import pmctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  upd_t             upd,
    output logic [REG_W-1:0] cur,
    output logic             req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            req <= 1'b0;
        end else begin
            if (upd.load) cur <= upd.next_val;
            req <= upd.fire;
        end
    end
endmodule

// File: rtl/pmctl_rdmux.sv
module pmctl_rdmux
    import pmctl_pkg::*;
(
    input  logic             rd_en,
    input  logic             size_word,
    input  logic             addr_hi,
    input  logic [REG_W-1:0] cur,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] vis;
    assign vis = cur & ~hide_mask();

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (size_word)    rdata = vis;
            else if (addr_hi) rdata[LANE_W-1:0] = vis[REG_W-1:LANE_W];
            else              rdata[LANE_W-1:0] = vis[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/pmctl_reg.sv
module pmctl_reg
    import pmctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             size_word,
    input  logic             addr_hi,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             shutdown_req
);
    upd_t             upd;
    logic [REG_W-1:0] cur;

    pmctl_decode u_decode (
        .wr_en     (wr_en),
        .size_word (size_word),
        .addr_hi   (addr_hi),
        .wdata     (wdata),
        .cur       (cur),
        .upd       (upd)
    );

    pmctl_store u_store (
        .clk (clk),
        .rst (rst),
        .upd (upd),
        .cur (cur),
        .req (shutdown_req)
    );

    pmctl_rdmux u_rdmux (
        .rd_en     (rd_en),
        .size_word (size_word),
        .addr_hi   (addr_hi),
        .cur       (cur),
        .rdata     (rdata)
    );
endmodule

// File: rtl/pmctl_reg_chk.sv
module pmctl_reg_chk
    import pmctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             size_word,
    input logic             addr_hi,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] rdata,
    input logic             shutdown_req
);
    // R1: the cycle after reset carries no request
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !shutdown_req);

    // R2: hidden bits never visible
    a_r2_hidden_bits: assert property (@(posedge clk) disable iff (rst)
        (rdata[GREL_BIT] == 1'b0) && (rdata[SLP_BIT] == 1'b0));

    // R5: byte reads zero-extended, idle reads zero
    a_r5_byte_zext: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !size_word) |-> (rdata[REG_W-1:LANE_W] == '0));
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));

    // R6: qualifying word write gives a request next cycle
    a_r6_word_fires: assert property (@(posedge clk) disable iff (rst)
        (wr_en && size_word && wdata[SLP_BIT] && wdata[TYPE_LSB +: TYPE_W] == '0)
        |=> shutdown_req);

    // R7: qualifying high-lane write gives a request next cycle
    a_r7_hi_fires: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !size_word && addr_hi && wdata[SLP_BIT-LANE_W]
         && wdata[TYPE_LSB-LANE_W +: TYPE_W] == '0) |=> shutdown_req);

    // R8: nonzero sleep type on a word write never requests
    a_r8_word_type_blocks: assert property (@(posedge clk) disable iff (rst)
        (wr_en && size_word && wdata[TYPE_LSB +: TYPE_W] != '0) |=> !shutdown_req);

    // R9: low-lane writes never request
    a_r9_lo_silent: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !size_word && !addr_hi) |=> !shutdown_req);

    // R6: a request is always caused by a write one cycle earlier
    a_r6_needs_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && shutdown_req) |-> $past(wr_en));
endmodule

bind pmctl_reg pmctl_reg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .size_word    (size_word),
    .addr_hi      (addr_hi),
    .wdata        (wdata),
    .rdata        (rdata),
    .shutdown_req (shutdown_req)
);

// File: tb/pmctl_reg_tb.sv
module pmctl_reg_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        size_word = 1'b0;
    logic        addr_hi = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        shutdown_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pmctl_reg u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .size_word(size_word), .addr_hi(addr_hi), .wdata(wdata),
        .rdata(rdata), .shutdown_req(shutdown_req)
    );

    // op: 0 word write, 1 low-lane write, 2 high-lane write
    // fields: op[1:0], data[15:0], expected word read[15:0], expected pulse
    localparam int NV = 12;
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 16'h1405, 16'h1401, 1'b0},  // R2 type 101
        {2'd0, 16'h3C05, 16'h1C01, 1'b0},  // R8 reserved 111
        {2'd1, 16'h00A7, 16'h1CA3, 1'b0},  // R3
        {2'd1, 16'h2020, 16'h1C20, 1'b0},  // R9 upper data ignored
        {2'd2, 16'h0021, 16'h0120, 1'b1},  // R7 soft-off via high lane
        {2'd2, 16'h003D, 16'h1D20, 1'b0},  // R8 high lane type 111
        {2'd2, 16'h0024, 16'h0420, 1'b0},  // R8 high lane type 001
        {2'd0, 16'h2001, 16'h0001, 1'b1},  // R6 soft-off via word
        {2'd0, 16'h2801, 16'h0801, 1'b0},  // R8 type 010
        {2'd0, 16'h0000, 16'h0000, 1'b0},  // R8 sleep clear
        {2'd0, 16'hFFFF, 16'hDFFB, 1'b0},  // R2 all ones
        {2'd2, 16'h0080, 16'h80FB, 1'b0}   // R4 keeps low lane
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; size_word = 0; addr_hi = 0; wdata = '0;
    endtask

    task automatic do_read(input logic word, input logic hi);
        rd_en = 1; size_word = word; addr_hi = hi; wr_en = 0;
        #1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        do_read(1, 0);
        check("R1 reset value", rdata, 16'h0000);
        check("R1 reset pulse", {15'b0, shutdown_req}, 16'h0);
        idle();

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = 1; wdata = VEC[i][32:17];
            size_word = (VEC[i][34:33] == 2'd0);
            addr_hi   = (VEC[i][34:33] == 2'd2);
            @(negedge clk);
            do_read(1, 0);
            check($sformatf("R2/R3/R4 vec %0d read", i), rdata, VEC[i][16:1]);
            check($sformatf("R6/R7/R8/R9 vec %0d pulse", i), {15'b0, shutdown_req}, {15'b0, VEC[i][0]});
            idle();
            @(negedge clk);
            check($sformatf("R6 vec %0d pulse width", i), {15'b0, shutdown_req}, 16'h0);
        end

        // R5 byte reads of 0x80FF stored
        do_read(0, 0);
        check("R5 low lane read", rdata, 16'h00FB);
        do_read(0, 1);
        check("R5 high lane read", rdata, 16'h0080);
        rd_en = 0; #1;
        check("R5 idle read", rdata, 16'h0000);
        idle();

        // R10 read during write sees old value
        @(negedge clk);
        wr_en = 1; rd_en = 1; size_word = 1; wdata = 16'h1234;
        #1;
        check("R10 read during write", rdata, 16'h80FB);
        @(negedge clk);
        idle();
        do_read(1, 0);
        check("R10 value after write", rdata, 16'h1230);
        idle();

        // R1 reset while a soft-off write is presented
        @(negedge clk);
        rst = 1; wr_en = 1; size_word = 1; wdata = 16'h2000;
        @(negedge clk);
        idle();
        rst = 0;
        do_read(1, 0);
        check("R1 mid-run reset value", rdata, 16'h0000);
        check("R1 mid-run reset pulse", {15'b0, shutdown_req}, 16'h0);
        idle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule